// File: doc/BRIEF.md
# Compressed Table-Jump Unit

This block carries out 16-bit table-jump instructions. A table register, reachable through a small CSR port, holds the base address of a jump table and a mode field. When a recognised instruction arrives, the unit checks that it is allowed to run. It then forms the address of the table entry from the 8-bit index in the instruction and fetches that entry over a single-outstanding instruction-memory port. The fetched entry, with bit 0 cleared, becomes the new PC.

Indices of 32 and above are the linking form. For these, the unit also produces the address of the next instruction for register x1. The register width is chosen at run time: the `xlen64` input selects a 64-bit width when high and a 32-bit width when low. A core front end feeds one instruction at a time. The unit holds `busy` while it works and reports the result as a single-cycle pulse, either a redirect (plus an optional link write) or an exception.

Top module: `tj_unit`

## Requirements
- R1: An instruction is recognised only when bits [15:13] = 3'b101, bits [12:10] = 3'b000 and bits [1:0] = 2'b10, and its table index is bits [9:2]. Any other word presented on `instr_valid` is ignored: `busy`, `mem_req_valid` and `done_valid` all stay low.
- R2: The table register answers CSR address 12'h017 and resets to zero. A legal write stores `csr_wdata`, keeping only the low 32 bits (zero-extended) when `xlen64` = 0. A legal read returns the register, or its low 32 bits zero-extended when `xlen64` = 0. Any other address gives `csr_hit` = 0.
- R3: A CSR access to the table register reports `csr_exc` = 1 (illegal) when `ext_present` = 0. When `tbl_enable` = 0 it reports 1, or 2 (virtual) if `virt_mode` = 1. A faulting write leaves the register unchanged. `csr_exc` = 0 means no exception.
- R4: A recognised instruction is gated the same way as a CSR access, in the same priority order: `ext_present` = 0 gives code 1, and `tbl_enable` = 0 gives code 2 if virtualized and code 1 otherwise. The result is `exc_valid` with that code, and no memory request is issued.
- R5: The mode field is the register's bits [5:0]. If it is nonzero, a permitted instruction ends with `exc_valid`, code 1, no memory request, no redirect and no link write.
- R6: The base is the register with bits [5:0] forced to zero. With `xlen64` = 1 the request address is base + index×8 and `mem_req_wide` = 1. With `xlen64` = 0 the address is (base + index×4) mod 2^32 and `mem_req_wide` = 0.
- R7: For an index of 32 or more, the result carries `link_we` = 1 with `link_data` = `instr_pc` + 2, taken mod 2^32 when `xlen64` = 0. For an index below 32, `link_we` = 0.
- R8: `redirect_pc` is the fetched word with bit 0 cleared. When `xlen64` = 0, only the low 32 bits of the word are used, zero-extended.
- R9: A response with `mem_rsp_fault` = 1 ends the instruction with `exc_valid`, code 3 (access fault), and with neither a redirect nor a link write.
- R10: `busy` rises in the cycle after an instruction is accepted and stays high through the result cycle. `instr_valid` is ignored while `busy` is high.
- R11: The result (`done_valid` together with the redirect and link outputs, or the exception) lasts exactly one cycle.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlen64 | input | 1 | 1 selects 64-bit width, 0 selects 32-bit |
| ext_present | input | 1 | Table-jump support is implemented |
| tbl_enable | input | 1 | State-enable permission bit for the table feature |
| virt_mode | input | 1 | Hart is running virtualized |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | CSR write data |
| csr_hit | output | 1 | Access addresses the table register |
| csr_rdata | output | 64 | CSR read data |
| csr_exc | output | 2 | CSR access exception code |
| instr_valid | input | 1 | Instruction presented |
| instr | input | 16 | Instruction word |
| instr_pc | input | 64 | PC of the instruction |
| busy | output | 1 | Instruction in progress |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Entry address |
| mem_req_wide | output | 1 | 1 = 64-bit fetch, 0 = 32-bit fetch |
| mem_rsp_valid | input | 1 | Fetch response |
| mem_rsp_data | input | 64 | Fetched entry |
| mem_rsp_fault | input | 1 | Fetch failed |
| done_valid | output | 1 | Result pulse |
| redirect_valid | output | 1 | Redirect the PC |
| redirect_pc | output | 64 | New PC |
| link_we | output | 1 | Write x1 |
| link_data | output | 64 | Value for x1 |
| exc_valid | output | 1 | Instruction raised an exception |
| exc_code | output | 2 | Exception code |

## Verification
The bench runs every one of the 256 indices in both widths. It uses a base near the top of the 32-bit space, so the entry address and the link value both wrap there. A unit that scaled by the wrong stride, kept upper bits in 32-bit mode or got the link threshold wrong by one would miss an index.

It also tries all 63 nonzero mode values, every combination of the gating inputs, a faulting fetch, request stalls of several lengths, and an instruction offered while the unit is busy. Each of these is aimed at a particular fault:
- A unit that fetched despite an exception would show a request.
- One that redirected on a fault would show a redirect.
- One that dropped the request during a stall would show a gap in `mem_req_valid`.
- One that started a second instruction would leave `busy` high after the result.

// File: rtl/tj_pkg.sv
// Shared constants, state and exception types for the table-jump unit.
// Assumes the widest register width is 64 and the narrow width is half of it.
package tj_pkg;
    parameter int XW_DEF      = 64;     // widest register width
    parameter int IW_DEF      = 8;      // table index width
    parameter int MW_DEF      = 6;      // mode field width
    parameter int CAW_DEF     = 12;     // CSR address width
    parameter logic [11:0] TBL_CSR_ADDR = 12'h017;
    parameter int LINK_MIN    = 32;     // first index of the linking form

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRTUAL = 2'd2,
        EXC_ACCESS  = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } fsm_e;

    // Permission check shared by CSR accesses and instructions.
    function automatic exc_e access_gate(logic ext, logic en, logic virt);
        if (!ext)     return EXC_ILLEGAL;
        else if (!en) return virt ? EXC_VIRTUAL : EXC_ILLEGAL;
        else          return EXC_NONE;
    endfunction
endpackage

// File: rtl/tj_csr.sv
// Table register with its CSR access port.
// Access checks are combinational; a write lands on the next clock edge.
// Assumes XW is even and that the narrow width is XW/2.
module tj_csr
    import tj_pkg::*;
#(
    parameter int XW  = XW_DEF,
    parameter int CAW = CAW_DEF,
    parameter logic [CAW-1:0] ADDR = CAW'(TBL_CSR_ADDR)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xlen64,
    input  logic           ext_present,
    input  logic           tbl_enable,
    input  logic           virt_mode,
    input  logic           csr_valid,
    input  logic           csr_we,
    input  logic [CAW-1:0] csr_addr,
    input  logic [XW-1:0]  csr_wdata,
    output logic           csr_hit,
    output logic [XW-1:0]  csr_rdata,
    output exc_e           csr_exc,
    output logic [XW-1:0]  tbl_q
);
    localparam int HW = XW / 2;

    logic [XW-1:0] wr_val;

    // Decode the address, check permission and form read data.
    always_comb begin
        csr_hit   = csr_valid && (csr_addr == ADDR);
        csr_exc   = csr_hit ? access_gate(ext_present, tbl_enable, virt_mode) : EXC_NONE;
        wr_val    = xlen64 ? csr_wdata : {{HW{1'b0}}, csr_wdata[HW-1:0]};
        csr_rdata = '0;
        if (csr_hit && csr_exc == EXC_NONE)
            csr_rdata = xlen64 ? tbl_q : {{HW{1'b0}}, tbl_q[HW-1:0]};
    end

    // Hold the table register; clear on reset, update on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_q <= '0;
        else if (csr_hit && csr_we && csr_exc == EXC_NONE)
            tbl_q <= wr_val;
    end

    AST_CSR_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && csr_we && csr_exc != EXC_NONE) |=> $stable(tbl_q)); // R3
endmodule

// File: rtl/tj_decode.sv
// Combinational decode of the table-jump word, legality check and address math.
// Assumes XW is even, the narrow width is XW/2, and XW > IW + 3.
module tj_decode
    import tj_pkg::*;
#(
    parameter int XW = XW_DEF,
    parameter int IW = IW_DEF,
    parameter int MW = MW_DEF
) (
    input  logic [15:0]   instr,
    input  logic [XW-1:0] instr_pc,
    input  logic [XW-1:0] tbl_q,
    input  logic          xlen64,
    input  logic          ext_present,
    input  logic          tbl_enable,
    input  logic          virt_mode,
    output logic          match,
    output logic          link,
    output exc_e          pre_exc,
    output logic [XW-1:0] entry_addr,
    output logic [XW-1:0] link_addr
);
    localparam int HW = XW / 2;

    logic [IW-1:0] idx;
    logic [XW-1:0] base;
    logic [XW-1:0] off;
    logic [XW-1:0] sum;
    logic [XW-1:0] nxt;

    // Recognise the opcode, then form the entry address and the link value.
    always_comb begin
        match = (instr[15:13] == 3'b101) && (instr[12:10] == 3'b000) && (instr[1:0] == 2'b10);
        idx   = instr[IW+1:2];
        link  = (int'(idx) >= LINK_MIN);
        base  = {tbl_q[XW-1:MW], {MW{1'b0}}};
        off   = xlen64 ? {{(XW-IW-3){1'b0}}, idx, 3'b000}
                       : {{(XW-IW-2){1'b0}}, idx, 2'b00};
        sum   = base + off;
        nxt   = instr_pc + XW'(2);
        entry_addr = xlen64 ? sum : {{HW{1'b0}}, sum[HW-1:0]};
        link_addr  = xlen64 ? nxt : {{HW{1'b0}}, nxt[HW-1:0]};
        pre_exc = access_gate(ext_present, tbl_enable, virt_mode);
        if (pre_exc == EXC_NONE && tbl_q[MW-1:0] != '0)
            pre_exc = EXC_ILLEGAL;
    end
endmodule

// File: rtl/tj_fetch_fsm.sv
// Sequencer for one table-entry fetch: idle, request, wait, done.
// Assumes memory answers each accepted request with exactly one response.
module tj_fetch_fsm
    import tj_pkg::*;
#(
    parameter int XW = XW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  exc_e          pre_exc,
    input  logic [XW-1:0] addr,
    input  logic          wide,
    output logic          busy,
    output logic          done,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [XW-1:0] mem_req_addr,
    output logic          mem_req_wide,
    input  logic          mem_rsp_valid,
    input  logic [XW-1:0] mem_rsp_data,
    input  logic          mem_rsp_fault,
    output exc_e          exc_q,
    output logic [XW-1:0] data_q
);
    fsm_e state;

    // Step the sequence and capture the request context and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            exc_q        <= EXC_NONE;
            data_q       <= '0;
            mem_req_addr <= '0;
            mem_req_wide <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    mem_req_addr <= addr;
                    mem_req_wide <= wide;
                    exc_q        <= pre_exc;
                    state        <= (pre_exc == EXC_NONE) ? ST_REQ : ST_DONE;
                end
                ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    data_q <= mem_rsp_data;
                    if (mem_rsp_fault) exc_q <= EXC_ACCESS;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Derive handshake and status outputs from the state.
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        mem_req_valid = (state == ST_REQ);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

// File: rtl/tj_unit.sv
// Table-jump unit top: table register, decoder, fetch sequencer, result outputs.
// Assumes one instruction at a time, presented only while busy is low.
module tj_unit
    import tj_pkg::*;
#(
    parameter int XW  = XW_DEF,
    parameter int IW  = IW_DEF,
    parameter int MW  = MW_DEF,
    parameter int CAW = CAW_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xlen64,
    input  logic           ext_present,
    input  logic           tbl_enable,
    input  logic           virt_mode,
    input  logic           csr_valid,
    input  logic           csr_we,
    input  logic [CAW-1:0] csr_addr,
    input  logic [XW-1:0]  csr_wdata,
    output logic           csr_hit,
    output logic [XW-1:0]  csr_rdata,
    output logic [1:0]     csr_exc,
    input  logic           instr_valid,
    input  logic [15:0]    instr,
    input  logic [XW-1:0]  instr_pc,
    output logic           busy,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [XW-1:0]  mem_req_addr,
    output logic           mem_req_wide,
    input  logic           mem_rsp_valid,
    input  logic [XW-1:0]  mem_rsp_data,
    input  logic           mem_rsp_fault,
    output logic           done_valid,
    output logic           redirect_valid,
    output logic [XW-1:0]  redirect_pc,
    output logic           link_we,
    output logic [XW-1:0]  link_data,
    output logic           exc_valid,
    output logic [1:0]     exc_code
);
    localparam int HW = XW / 2;

    logic [XW-1:0] tbl_q;
    exc_e          csr_exc_e;
    logic          match, link, accept, done;
    exc_e          pre_exc, exc_q;
    logic [XW-1:0] entry_addr, link_addr, data_q;
    logic          link_q;
    logic [XW-1:0] link_data_q;

    tj_csr #(.XW(XW), .CAW(CAW)) u_csr (
        .clk(clk), .rst_n(rst_n), .xlen64(xlen64), .ext_present(ext_present),
        .tbl_enable(tbl_enable), .virt_mode(virt_mode), .csr_valid(csr_valid),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_hit(csr_hit), .csr_rdata(csr_rdata), .csr_exc(csr_exc_e), .tbl_q(tbl_q)
    );

    tj_decode #(.XW(XW), .IW(IW), .MW(MW)) u_dec (
        .instr(instr), .instr_pc(instr_pc), .tbl_q(tbl_q), .xlen64(xlen64),
        .ext_present(ext_present), .tbl_enable(tbl_enable), .virt_mode(virt_mode),
        .match(match), .link(link), .pre_exc(pre_exc),
        .entry_addr(entry_addr), .link_addr(link_addr)
    );

    tj_fetch_fsm #(.XW(XW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(accept), .pre_exc(pre_exc),
        .addr(entry_addr), .wide(xlen64), .busy(busy), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_fault(mem_rsp_fault), .exc_q(exc_q), .data_q(data_q)
    );

    // Accept a recognised instruction only while idle.
    always_comb accept = instr_valid && match && !busy;

    // Keep the link decision and value for the result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q      <= 1'b0;
            link_data_q <= '0;
        end else if (accept) begin
            link_q      <= link;
            link_data_q <= link_addr;
        end
    end

    // Form the single-cycle result from the sequencer's captured state.
    always_comb begin
        csr_exc        = csr_exc_e;
        done_valid     = done;
        redirect_valid = done && (exc_q == EXC_NONE);
        redirect_pc    = mem_req_wide ? {data_q[XW-1:1], 1'b0}
                                      : {{HW{1'b0}}, data_q[HW-1:1], 1'b0};
        link_we        = redirect_valid && link_q;
        link_data      = link_data_q;
        exc_valid      = done && (exc_q != EXC_NONE);
        exc_code       = exc_q;
    end

    AST_NO_FETCH_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pre_exc != EXC_NONE) |=> (!mem_req_valid && exc_valid)); // R5
    AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid && !done_valid && mem_rsp_valid && mem_rsp_fault)
        |=> (exc_valid && exc_code == EXC_ACCESS && !redirect_valid && !link_we)); // R9
endmodule

// File: tb/tb_tj_unit.sv
`timescale 1ns/1ps
module tb_tj_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlen64 = 1'b1, ext_present = 1'b1, tbl_enable = 1'b1, virt_mode = 1'b0;
    logic        csr_valid = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_hit;
    logic [63:0] csr_rdata;
    logic [1:0]  csr_exc;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [63:0] instr_pc = '0;
    logic        busy, mem_req_valid, mem_req_wide;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
    logic [63:0] mem_req_addr, mem_rsp_data = '0;
    logic        done_valid, redirect_valid, link_we, exc_valid;
    logic [63:0] redirect_pc, link_data;
    logic [1:0]  exc_code;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tj_unit dut (
        .clk(clk), .rst_n(rst_n), .xlen64(xlen64), .ext_present(ext_present),
        .tbl_enable(tbl_enable), .virt_mode(virt_mode), .csr_valid(csr_valid),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_hit(csr_hit), .csr_rdata(csr_rdata), .csr_exc(csr_exc),
        .instr_valid(instr_valid), .instr(instr), .instr_pc(instr_pc), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_fault(mem_rsp_fault), .done_valid(done_valid),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .link_we(link_we), .link_data(link_data), .exc_valid(exc_valid),
        .exc_code(exc_code)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3C3_3C3C, a[31:0] ^ 32'h0F0F_F0F1};
    endfunction

    function automatic logic [15:0] enc(input logic [7:0] idx);
        return {3'b101, 3'b000, idx, 2'b10};
    endfunction

    task automatic csr_op(input bit we, input logic [11:0] a, input logic [63:0] wd,
                          output bit hit, output logic [1:0] ex, output logic [63:0] rd);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
        #1;
        hit = csr_hit; ex = csr_exc; rd = csr_rdata;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
    endtask

    // Present one instruction, serve its fetch, and capture the result pulse.
    task automatic run_insn(input logic [15:0] iw, input logic [63:0] pc, input int stall,
                            input int lat, input bit fault, input bit poke,
                            output bit saw_req, output logic [63:0] raddr, output bit rwide,
                            output bit saw_done, output bit rv, output logic [63:0] rpc,
                            output bit lwe, output logic [63:0] ldat, output bit ev,
                            output logic [1:0] ec, output bit seq_ok);
        @(negedge clk);
        instr_valid = 1'b1; instr = iw; instr_pc = pc;
        @(negedge clk);
        instr_valid = 1'b0;
        saw_req = 0; saw_done = 0; seq_ok = 1; raddr = '0; rwide = 0;
        rv = 0; rpc = '0; lwe = 0; ldat = '0; ev = 0; ec = '0;
        for (int c = 0; c < 60 && !saw_done; c++) begin
            if (!busy) seq_ok = 0;
            if (done_valid) begin
                saw_done = 1; rv = redirect_valid; rpc = redirect_pc; lwe = link_we;
                ldat = link_data; ev = exc_valid; ec = exc_code;
            end else if (mem_req_valid) begin
                saw_req = 1; raddr = mem_req_addr; rwide = mem_req_wide;
                for (int s = 0; s < stall; s++) begin
                    if (poke) begin instr_valid = 1'b1; instr = enc(8'd63); end
                    @(negedge clk);
                    instr_valid = 1'b0;
                    if (!mem_req_valid || mem_req_addr != raddr) seq_ok = 0;
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (mem_req_valid) seq_ok = 0;
                for (int l = 0; l < lat; l++) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(raddr); mem_rsp_fault = fault;
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        if (done_valid || busy || mem_req_valid) seq_ok = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit hit, sr, sw, sd, rv, lwe, ev, ok;
        logic [1:0] ex, ec;
        logic [63:0] rd, ra, rpc, ld, base, pc, ea, er, el;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: idle, no request, no result (R10, R11).
        check(!busy && !mem_req_valid && !done_valid, "R10 reset idle", {61'd0, busy, mem_req_valid, done_valid}, 64'd0);
        csr_op(0, 12'h017, 0, hit, ex, rd);
        check(hit && ex == 0 && rd == 0, "R2 reset value", rd, 64'd0);

        // CSR write/read and address decode (R2).
        base = 64'h0000_1234_5678_9AC0;
        csr_op(1, 12'h017, base, hit, ex, rd);
        csr_op(0, 12'h017, 0, hit, ex, rd);
        check(hit && rd == base, "R2 readback", rd, base);
        csr_op(1, 12'h018, 64'hFFFF, hit, ex, rd);
        check(!hit, "R2 other address", {63'd0, hit}, 64'd0);
        csr_op(0, 12'h017, 0, hit, ex, rd);
        check(rd == base, "R2 other address no write", rd, base);

        // CSR gating (R3).
        ext_present = 0;
        csr_op(1, 12'h017, 64'h40, hit, ex, rd);
        check(ex == 2'd1, "R3 csr ext absent", {62'd0, ex}, 64'd1);
        ext_present = 1; tbl_enable = 0;
        csr_op(1, 12'h017, 64'h80, hit, ex, rd);
        check(ex == 2'd1, "R3 csr disabled", {62'd0, ex}, 64'd1);
        virt_mode = 1;
        csr_op(1, 12'h017, 64'hC0, hit, ex, rd);
        check(ex == 2'd2, "R3 csr disabled virt", {62'd0, ex}, 64'd2);
        tbl_enable = 1; virt_mode = 0;
        csr_op(0, 12'h017, 0, hit, ex, rd);
        check(rd == base, "R3 blocked writes left value", rd, base);

        // Full index sweep, 64-bit width (R1 R6 R7 R8 R10 R11 R12).
        for (int i = 0; i < 256; i++) begin
            pc = 64'h0000_0000_8000_0100 + 64'(i) * 2;
            run_insn(enc(8'(i)), pc, i % 3, i % 2, 0, 0, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
            ea = base + 64'(i) * 8;
            er = mem_word(ea) & ~64'd1;
            el = pc + 2;
            check(sr && ra == ea && sw, "R6 wide address", ra, ea);
            check(sd && rv && !ev && rpc == er, "R8 wide target", rpc, er);
            check(lwe == (i >= 32) && (!lwe || ld == el), "R7 wide link", {lwe, ld[62:0]}, {(i >= 32), el[62:0]});
            check(ok, "R11 R12 R10 sequence", {63'd0, ok}, 64'd1);
        end

        // Full index sweep, 32-bit width with wraparound (R2 R6 R7 R8).
        xlen64 = 0;
        csr_op(1, 12'h017, 64'hABCD_0000_FFFF_FFC0, hit, ex, rd);
        csr_op(0, 12'h017, 0, hit, ex, rd);
        check(rd == 64'h0000_0000_FFFF_FFC0, "R2 narrow readback", rd, 64'h0000_0000_FFFF_FFC0);
        for (int i = 0; i < 256; i++) begin
            pc = 64'h0000_0000_FFFF_FF00 + 64'(i) * 2;
            run_insn(enc(8'(i)), pc, (i + 1) % 3, i % 2, 0, 0, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
            ea = {32'd0, 32'hFFFF_FFC0 + 32'(i) * 4};
            er = {32'd0, mem_word(ea)[31:1], 1'b0};
            el = {32'd0, pc[31:0] + 32'd2};
            check(sr && ra == ea && !sw, "R6 narrow address", ra, ea);
            check(sd && rv && !ev && rpc == er, "R8 narrow target", rpc, er);
            check(lwe == (i >= 32) && (!lwe || ld == el), "R7 narrow link", {lwe, ld[62:0]}, {(i >= 32), el[62:0]});
            check(ok, "R11 narrow sequence", {63'd0, ok}, 64'd1);
        end

        // Every nonzero mode value is illegal (R5).
        xlen64 = 1;
        for (int m = 1; m < 64; m++) begin
            csr_op(1, 12'h017, base | 64'(m), hit, ex, rd);
            run_insn(enc(8'd40), 64'h100, 0, 0, 0, 0, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
            check(!sr && sd && ev && ec == 2'd1 && !rv && !lwe && ok, "R5 mode nonzero", {62'd0, ec}, 64'd1);
        end
        csr_op(1, 12'h017, base, hit, ex, rd);

        // Instruction gating, all combinations (R4).
        for (int g = 0; g < 8; g++) begin
            logic [1:0] want;
            ext_present = g[0]; tbl_enable = g[1]; virt_mode = g[2];
            want = !g[0] ? 2'd1 : (!g[1] ? (g[2] ? 2'd2 : 2'd1) : 2'd0);
            run_insn(enc(8'd5), 64'h200, 0, 0, 0, 0, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
            if (want == 0)
                check(sr && rv && !ev, "R4 permitted", {63'd0, rv}, 64'd1);
            else
                check(!sr && ev && ec == want && !rv, "R4 gated", {62'd0, ec}, {62'd0, want});
        end
        ext_present = 1; tbl_enable = 1; virt_mode = 0;

        // Fetch fault aborts (R9).
        run_insn(enc(8'd50), 64'h300, 1, 1, 1, 0, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
        check(sr && sd && ev && ec == 2'd3 && !rv && !lwe, "R9 fault abort", {62'd0, ec}, 64'd3);

        // Instruction offered while busy is ignored (R10).
        run_insn(enc(8'd7), 64'h400, 3, 2, 0, 1, sr, ra, sw, sd, rv, rpc, lwe, ld, ev, ec, ok);
        ea = base + 64'd56;
        check(ra == ea && rv && !lwe && ok, "R10 busy ignores new instr", ra, ea);

        // Non-matching words are ignored (R1).
        for (int p = 0; p < 5; p++) begin
            logic [15:0] bad;
            bit quiet;
            case (p)
                0: bad = 16'b100_000_00000101_10;
                1: bad = 16'b101_001_00000101_10;
                2: bad = 16'b101_000_00000101_01;
                3: bad = 16'b101_100_00000101_10;
                default: bad = 16'b111_000_00000101_10;
            endcase
            @(negedge clk);
            instr_valid = 1'b1; instr = bad;
            @(negedge clk);
            instr_valid = 1'b0;
            quiet = 1;
            for (int c = 0; c < 3; c++) begin
                if (busy || mem_req_valid || done_valid) quiet = 0;
                @(negedge clk);
            end
            check(quiet, "R1 non-matching ignored", {63'd0, quiet}, 64'd1);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule